// File: doc/BRIEF.md
# Instruction Completion Change Detector

This block decides when the result of the instruction now executing has settled, and raises a `done` pulse that restarts the external step generator. It watches one of two 32-bit result buses: the register-writeback value or the next-address value. The instruction class, supplied with the start strobe, picks the bus. A registered snapshot of the watched bus is compared every cycle with the live bus. The first difference after a masking window produces a `done` pulse of programmable width. Instructions whose result is identical to the previous one produce no difference, so no pulse is raised and the external timeout advances execution.

The control is a five-state machine. The states are `ST_IDLE` (after reset, nothing watched), `ST_MASK` (masking window after a start), `ST_WATCH` (comparing), `ST_PULSE` (`done` high) and `ST_SPENT` (pulse already given for this instruction). The transitions are:
- start: any state to `ST_MASK`, which captures the class and the live selected bus.
- mask-expire: `ST_MASK` to `ST_WATCH` after `MASK_CYC` cycles.
- hit: `ST_WATCH` to `ST_PULSE` on a difference, for the ALU and jump/branch classes only.
- pulse-expire: `ST_PULSE` to `ST_SPENT` after `PULSE_W` cycles.

Both `MASK_CYC` and `PULSE_W` must be at least 1.

Top module: `settle_detect`

## Requirements
- R1: While reset is held and after reset, before the first start strobe, `done` is 0 whatever the buses do.
- R2: Class 2'b00 (ALU) compares the writeback bus `wb_val`; changes on `nxt_addr` give no `done`.
- R3: Class 2'b01 (jump/branch) compares `nxt_addr`; changes on `wb_val` give no `done`.
- R4: Classes 2'b10 and 2'b11 never raise `done`, whatever either bus does.
- R5: Let the start strobe be sampled at clock edge k. A change on the watched bus that is first sampled at edge k+MASK_CYC+1 or later is detected. `done` goes high right after the edge where the change is first sampled.
- R6: Changes first sampled at edges k+1 through k+MASK_CYC are absorbed into the snapshot and never give `done`.
- R7: `done` stays high for exactly `PULSE_W` cycles.
- R8: At most one pulse is given per instruction. Changes after the pulse are ignored until the next start strobe.
- R9: A start strobe sampled while `done` is high drops `done` after that edge and begins a new instruction, which can raise its own pulse.
- R10: Writing the same value that the snapshot holds gives no `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wb_val | input | 32 | Live register-writeback result |
| nxt_addr | input | 32 | Live next-address result |
| insn_class | input | 2 | Class of the instruction, sampled with `start` |
| start | input | 1 | One-cycle strobe at the start of each instruction |
| done | output | 1 | Completion pulse |

## Verification
Inputs are driven at the falling edge and `done` is sampled at the falling edges that follow, indexed from the first falling edge after the start edge (index 0). A change driven at index d is sampled at rising edge k+d+1. It is therefore expected on `done` at indices d+1 through d+PULSE_W when d is at least MASK_CYC, and never otherwise. The bench sweeps every class, each bus, a same-value write and every change delay across the window. For each trial it builds the expected bit vector arithmetically and compares it with the observed one. Pulse truncation by a fresh start is expected at the very next sample.

// File: rtl/settle_pkg.sv
package settle_pkg;

    typedef enum logic [1:0] {
        CLS_ALU   = 2'b00,
        CLS_JUMP  = 2'b01,
        CLS_OTHER = 2'b10,
        CLS_RSVD  = 2'b11
    } insn_cls_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_MASK  = 3'd1,
        ST_WATCH = 3'd2,
        ST_PULSE = 3'd3,
        ST_SPENT = 3'd4
    } settle_st_e;

endpackage

// File: rtl/settle_bus_sel.sv
module settle_bus_sel
    import settle_pkg::*;
#(
    parameter int W = 32
) (
    input  insn_cls_e        cls,
    input  logic [W-1:0]     wb_bus,
    input  logic [W-1:0]     addr_bus,
    output logic [W-1:0]     picked
);
    // Jump/branch watches the address bus; all others fall back to writeback.
    always_comb begin
        picked = (cls == CLS_JUMP) ? addr_bus : wb_bus;
    end
endmodule

// File: rtl/settle_snap_cmp.sv
module settle_snap_cmp #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] live,
    output logic         differ
);
    logic [W-1:0] snap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_q <= '0;
        end else if (load) begin
            snap_q <= live;
        end
    end

    // High when the live bus has moved away from the stored copy.
    always_comb begin
        differ = (live != snap_q);
    end
endmodule

// File: rtl/settle_step_cnt.sv
module settle_step_cnt #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          dec,
    output logic          last
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    always_comb begin
        last = (cnt_q == CW'(1));
    end
endmodule

// File: rtl/settle_detect.sv
module settle_detect
    import settle_pkg::*;
#(
    parameter int W        = 32,
    parameter int MASK_CYC = 3,
    parameter int PULSE_W  = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [31:0]  wb_val,
    input  logic [31:0]  nxt_addr,
    input  logic [1:0]   insn_class,
    input  logic         start,
    output logic         done
);
    localparam int MAXC = (MASK_CYC > PULSE_W) ? MASK_CYC : PULSE_W;
    localparam int CW   = $clog2(MAXC + 1);
    localparam int RW   = $clog2(PULSE_W + 2);

    settle_st_e    state_q, state_d;
    insn_cls_e     cls_q;
    insn_cls_e     sel_cls;
    logic [W-1:0]  live_sel;
    logic          differ;
    logic          cnt_last;
    logic          cnt_load;
    logic [CW-1:0] cnt_val;
    logic          snap_load;
    logic          cls_silent;
    logic          hit;

    // On the start cycle, select by the incoming class; afterwards by the latched one.
    always_comb begin
        sel_cls    = start ? insn_cls_e'(insn_class) : cls_q;
        cls_silent = (cls_q == CLS_OTHER) || (cls_q == CLS_RSVD);
        hit        = (state_q == ST_WATCH) && differ && !cls_silent && !start;
        snap_load  = start || (state_q == ST_MASK);
        cnt_load   = start || hit;
        cnt_val    = start ? CW'(MASK_CYC) : CW'(PULSE_W);
    end

    settle_bus_sel #(.W(W)) u_sel (
        .cls      (sel_cls),
        .wb_bus   (wb_val[W-1:0]),
        .addr_bus (nxt_addr[W-1:0]),
        .picked   (live_sel)
    );

    settle_snap_cmp #(.W(W)) u_snap (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (snap_load),
        .live   (live_sel),
        .differ (differ)
    );

    settle_step_cnt #(.CW(CW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .dec      (1'b1),
        .last     (cnt_last)
    );

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        if (start) begin
            state_d = ST_MASK;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_MASK:  if (cnt_last) state_d = ST_WATCH;
                ST_WATCH: if (hit) state_d = ST_PULSE;
                ST_PULSE: if (cnt_last) state_d = ST_SPENT;
                ST_SPENT: state_d = ST_SPENT;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // State register and latched class.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cls_q   <= CLS_OTHER;
        end else begin
            state_q <= state_d;
            if (start) cls_q <= insn_cls_e'(insn_class);
        end
    end

    // Output decode.
    always_comb begin
        done = (state_q == ST_PULSE);
    end

    // Run-length of the current pulse, kept for the width check.
    logic [RW-1:0] run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_q <= '0;
        else if (done) run_q <= run_q + 1'b1;
        else           run_q <= '0;
    end

    AST_PULSE_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_q < RW'(PULSE_W))); // R7
    AST_START_ENDS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !done); // R9
    AST_SPENT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SPENT && !start) |=> !done); // R8
    AST_OTHER_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !cls_silent); // R4
    AST_DONE_NEEDS_DIFF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(differ)); // R5
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !start) |=> !done); // R1

endmodule

// File: tb/settle_detect_bench.sv
module settle_detect_bench;
    localparam int MASK_CYC = 3;
    localparam int PULSE_W  = 2;
    localparam int S        = MASK_CYC + PULSE_W + 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] wb_val = '0;
    logic [31:0] nxt_addr = '0;
    logic [1:0]  insn_class = '0;
    logic        start = 1'b0;
    logic        done;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    settle_detect #(.W(32), .MASK_CYC(MASK_CYC), .PULSE_W(PULSE_W)) u_settle_detect (
        .clk(clk), .rst_n(rst_n), .wb_val(wb_val), .nxt_addr(nxt_addr),
        .insn_class(insn_class), .start(start), .done(done)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // kind 0: flip wb_val, kind 1: flip nxt_addr, kind 2: rewrite wb_val unchanged
    task automatic run_trial(input int cls, input int kind, input int d, input logic [31:0] base);
        logic [31:0] obs, exp, flip;
        bit watched, detect;
        string tag;
        flip    = 32'h1 << ((cls * 7 + kind * 3 + d) % 32);
        watched = (kind == 0 && cls == 0) || (kind == 1 && cls == 1);
        detect  = watched && (d >= MASK_CYC);
        exp = '0;
        for (int s = 0; s < S; s++)
            if (detect && s >= d + 1 && s <= d + PULSE_W) exp[s] = 1'b1;
        @(negedge clk);
        wb_val = base; nxt_addr = ~base; insn_class = cls[1:0]; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        obs = '0;
        for (int s = 0; s < S; s++) begin
            if (s > 0) @(negedge clk);
            obs[s] = done;
            if (s == d) begin
                if (kind == 0) wb_val = wb_val ^ flip;
                else if (kind == 1) nxt_addr = nxt_addr ^ flip;
                else wb_val = base;
            end
            if (detect && s == d + PULSE_W + 1) begin
                wb_val = wb_val ^ 32'h8000_0001;
                nxt_addr = nxt_addr ^ 32'h8000_0001;
            end
        end
        if (kind == 2)          tag = "R10";
        else if (cls >= 2)      tag = "R4";
        else if (!watched)      tag = (cls == 0) ? "R2" : "R3";
        else if (d < MASK_CYC)  tag = "R6";
        else                    tag = (cls == 0) ? "R2 R5 R7 R8" : "R3 R5 R7 R8";
        check(tag, obs, exp);
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", checks, -1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] obs;
        @(negedge clk);
        check("R1 in reset", {31'b0, done}, 32'h0);
        wb_val = 32'h55;
        @(negedge clk);
        rst_n = 1'b1;
        obs = '0;
        for (int s = 0; s < 8; s++) begin
            @(negedge clk);
            obs[s] = done;
            wb_val = wb_val + 32'h3;
            nxt_addr = nxt_addr + 32'h4;
        end
        check("R1 before first start", obs, 32'h0);

        for (int cls = 0; cls < 4; cls++)
            for (int kind = 0; kind < 3; kind++)
                for (int d = 0; d <= MASK_CYC + 2; d++)
                    run_trial(cls, kind, d, 32'h1000_0000 + 32'(cls * 257 + kind * 17 + d));

        // R9: start during pulse ends it and a new pulse can follow.
        @(negedge clk);
        wb_val = 32'hA0; insn_class = 2'b00; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int s = 0; s < MASK_CYC; s++) @(negedge clk);
        wb_val = 32'hA1;
        @(negedge clk);
        check("R9 pulse present", {31'b0, done}, 32'h1);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R9 pulse cut", {31'b0, done}, 32'h0);
        obs = '0;
        for (int s = 1; s < S; s++) begin
            @(negedge clk);
            obs[s] = done;
            if (s == MASK_CYC) wb_val = 32'hA2;
        end
        check("R9 new instruction", obs, (32'((1 << PULSE_W) - 1)) << (MASK_CYC + 1));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule